// File: doc/BRIEF.md
# Doubling-Level SIMD Field Unit

This unit treats a 128-bit operand as four independent 32-bit lanes and applies one of three lane-wise functions to all lanes at once: parity, the smallest power of two not below the lane value, or a full bit mirror of the lane. A fourth opcode copies the operand unchanged. Every function is built from the same structure. A ladder of five levels works on sub-fields of width 2, 4, 8, 16 and 32. At each level, every sub-field combines its upper half with its lower half, and one half may be reshaped before the combine. Only the power-of-two function adds a per-lane decrement before the ladder and a per-lane increment after it.

Lanes and bits are numbered from the most significant end. Lane 0 is `in_data[127:96]`, and bit 0 of a lane is its most significant bit. An operand is offered with `in_valid`. The unit always accepts it (`in_ready` is held high), and the result appears in an output register on the next clock edge, flagged by a one-cycle `out_valid`.

Top module: `simd_fold_unit`

## Requirements
- R1: The operand is split into four 32-bit lanes, with lane 0 at bits [127:96] and lane 3 at bits [31:0]. Each lane's result depends only on that lane's input bits and the opcode.
- R2: Opcode 2'b00 (parity) writes, in each lane, 1 in the least significant bit if the lane holds an odd number of ones and 0 otherwise. The other 31 bits of the lane are 0.
- R3: Opcode 2'b01 (power-of-two ceiling) writes, for a lane value x with 1 ≤ x ≤ 32'h8000_0000, the smallest power of two that is greater than or equal to x.
- R4: Under opcode 2'b01, a lane value of 0 gives 0, and a lane value above 32'h8000_0000 gives 0 by wraparound.
- R5: Opcode 2'b10 (mirror) moves bit i of each lane to bit 31-i of the same lane.
- R6: Opcode 2'b11 copies the operand to the output unchanged.
- R7: `in_ready` is always 1. An input accepted at a clock edge sets `out_data` to its result and drives `out_valid` high at that same edge, for exactly one cycle.
- R8: In a cycle without an accepted input, `out_valid` is 0 after the next edge, and `out_data` keeps its previous value.
- R9: While `rst_n` is low, `out_valid` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and opcode are offered |
| in_ready | output | 1 | Always high: the unit takes one operand per cycle |
| in_op | input | 2 | Function select: 00 parity, 01 ceiling, 10 mirror, 11 copy |
| in_data | input | 128 | Operand, four 32-bit lanes, lane 0 most significant |
| out_valid | output | 1 | One-cycle flag for a new result |
| out_data | output | 128 | Registered result |

## Verification
All the datapath state sits between one input and the next output edge, so a wrong level mask, a swapped half or a missing carry shows on `out_data` in the very cycle after the faulty operand. The lane that is wrong points to the fault: a slip across a lane boundary corrupts a neighbouring lane, and a wrong wrap or carry shows only on the zero and above-2^31 ceiling inputs. A stuck or stretched valid register shows as an `out_valid` mismatch in the first idle cycle.

// File: rtl/simd_fold_pkg.sv
package simd_fold_pkg;

    typedef enum logic [1:0] {
        OP_PARITY  = 2'b00,
        OP_CEIL    = 2'b01,
        OP_MIRROR  = 2'b10,
        OP_COPY    = 2'b11
    } fold_op_e;

endpackage

// File: rtl/simd_fold_level.sv
// One doubling level: every sub-field of LVL_W bits combines its upper half
// (more significant) with its lower half.
module simd_fold_level
    import simd_fold_pkg::*;
#(
    parameter int REG_W = 128,
    parameter int LVL_W = 2
) (
    input  fold_op_e           op,
    input  logic [REG_W-1:0]   din,
    output logic [REG_W-1:0]   dout
);
    localparam int HALF = LVL_W / 2;
    localparam int NGRP = REG_W / LVL_W;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [HALF-1:0]  hi_h;
        logic [HALF-1:0]  lo_h;
        logic [HALF-1:0]  spread_h;
        logic [LVL_W-1:0] res;

        assign hi_h     = din[g*LVL_W + HALF +: HALF];
        assign lo_h     = din[g*LVL_W +: HALF];
        // upper half reshaped: all ones when it holds any one
        assign spread_h = {HALF{|hi_h}};

        always_comb begin
            unique case (op)
                OP_PARITY: res = {{HALF{1'b0}}, hi_h ^ lo_h};
                OP_CEIL:   res = {hi_h, lo_h | spread_h};
                OP_MIRROR: res = {lo_h, hi_h};
                default:   res = {hi_h, lo_h};
            endcase
        end

        assign dout[g*LVL_W +: LVL_W] = res;
    end

endmodule

// File: rtl/simd_lane_adjust.sv
// Lane-wide decrement (before the ladder) or increment (after it), applied
// only for the ceiling opcode.
module simd_lane_adjust
    import simd_fold_pkg::*;
#(
    parameter int REG_W   = 128,
    parameter int FIELD_W = 32,
    parameter bit INCR    = 1'b0
) (
    input  fold_op_e           op,
    input  logic [REG_W-1:0]   din,
    output logic [REG_W-1:0]   dout
);
    localparam int NFIELD = REG_W / FIELD_W;
    localparam logic [FIELD_W-1:0] ONE = FIELD_W'(1);

    for (genvar f = 0; f < NFIELD; f++) begin : g_lane
        logic [FIELD_W-1:0] lane;
        logic [FIELD_W-1:0] moved;

        assign lane = din[f*FIELD_W +: FIELD_W];

        if (INCR) begin : g_inc
            assign moved = lane + ONE;
        end else begin : g_dec
            assign moved = lane - ONE;
        end

        assign dout[f*FIELD_W +: FIELD_W] = (op == OP_CEIL) ? moved : lane;
    end

endmodule

// File: rtl/simd_fold_chain.sv
module simd_fold_chain
    import simd_fold_pkg::*;
#(
    parameter int REG_W   = 128,
    parameter int FIELD_W = 32
) (
    input  fold_op_e           op,
    input  logic [REG_W-1:0]   din,
    output logic [REG_W-1:0]   dout
);
    localparam int LEVELS = $clog2(FIELD_W);

    logic [LEVELS:0][REG_W-1:0] stage;

    simd_lane_adjust #(
        .REG_W   (REG_W),
        .FIELD_W (FIELD_W),
        .INCR    (1'b0)
    ) u_pre (
        .op   (op),
        .din  (din),
        .dout (stage[0])
    );

    for (genvar i = 0; i < LEVELS; i++) begin : g_level
        simd_fold_level #(
            .REG_W (REG_W),
            .LVL_W (2 << i)
        ) u_lvl (
            .op   (op),
            .din  (stage[i]),
            .dout (stage[i+1])
        );
    end

    simd_lane_adjust #(
        .REG_W   (REG_W),
        .FIELD_W (FIELD_W),
        .INCR    (1'b1)
    ) u_post (
        .op   (op),
        .din  (stage[LEVELS]),
        .dout (dout)
    );

endmodule

// File: rtl/simd_fold_unit.sv
module simd_fold_unit
    import simd_fold_pkg::*;
#(
    parameter int REG_W   = 128,
    parameter int FIELD_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [1:0]         in_op,
    input  logic [REG_W-1:0]   in_data,
    output logic               out_valid,
    output logic [REG_W-1:0]   out_data
);
    localparam int NFIELD = REG_W / FIELD_W;

    typedef struct packed {
        logic             vld;
        logic [REG_W-1:0] data;
    } unit_state_t;

    unit_state_t      state_d, state_q;
    logic             accept;
    fold_op_e         op_sel;
    logic [REG_W-1:0] chain_out;

    assign in_ready = 1'b1;
    assign accept   = in_valid && in_ready;
    assign op_sel   = fold_op_e'(in_op);

    simd_fold_chain #(
        .REG_W   (REG_W),
        .FIELD_W (FIELD_W)
    ) u_chain (
        .op   (op_sel),
        .din  (in_data),
        .dout (chain_out)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = accept;
        if (accept) begin
            state_d.data = chain_out;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign out_data  = state_q.data;

    // ---------------- assertions ----------------
    p_accept_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> (!out_valid && $stable(out_data)));

    p_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_op == 2'b11) |=> (out_data == $past(in_data)));

    for (genvar f = 0; f < NFIELD; f++) begin : g_lane_chk
        p_parity_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && in_op == 2'b00)
            |=> (out_data[f*FIELD_W + 1 +: FIELD_W-1] == '0));

        p_ceil_pow2_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && in_op == 2'b01)
            |=> ($countones(out_data[f*FIELD_W +: FIELD_W]) <= 1));

        p_mirror_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && in_op == 2'b10)
            |=> ($countones(out_data[f*FIELD_W +: FIELD_W])
                 == $countones($past(in_data[f*FIELD_W +: FIELD_W]))));
    end

endmodule

// File: tb/sim_simd_fold_unit.sv
module sim_simd_fold_unit;
    localparam int CLK_PERIOD = 10;
    localparam int REG_W      = 128;
    localparam int FIELD_W    = 32;
    localparam int NF         = REG_W / FIELD_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [1:0]       in_op = 2'b00;
    logic [REG_W-1:0] in_data = '0;
    logic             out_valid;
    logic [REG_W-1:0] out_data;

    int n_chk = 0;
    int n_bad = 0;

    logic             exp_vld = 1'b0;
    logic [REG_W-1:0] exp_data = '0;
    logic [1:0]       exp_op = 2'b00;
    logic [REG_W-1:0] exp_src = '0;
    logic [31:0]      rng = 32'h1bad_5eed;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_fold_unit #(.REG_W(REG_W), .FIELD_W(FIELD_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    // behavioural per-lane reference
    function automatic logic [31:0] lane_ref(input logic [1:0] op, input logic [31:0] x);
        logic [31:0] r;
        longint p;
        int ones;
        r = '0;
        case (op)
            2'b00: begin
                ones = 0;
                for (int b = 0; b < 32; b++) ones += int'(x[b]);
                r = (ones % 2 == 1) ? 32'd1 : 32'd0;
            end
            2'b01: begin
                if (x == 0 || x > 32'h8000_0000) r = '0;
                else begin
                    p = 1;
                    while (p < longint'(x)) p = p * 2;
                    r = 32'(p);
                end
            end
            2'b10: for (int b = 0; b < 32; b++) r[31-b] = x[b];
            default: r = x;
        endcase
        return r;
    endfunction

    function automatic logic [REG_W-1:0] reg_ref(input logic [1:0] op, input logic [REG_W-1:0] d);
        logic [REG_W-1:0] r;
        for (int f = 0; f < NF; f++) r[f*32 +: 32] = lane_ref(op, d[f*32 +: 32]);
        return r;
    endfunction

    function automatic string lane_tag(input logic [1:0] op, input logic [31:0] src);
        case (op)
            2'b00: return "R2";
            2'b01: return (src == 0 || src > 32'h8000_0000) ? "R4" : "R3";
            2'b10: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check_outputs();
        n_chk++;
        if (out_valid !== exp_vld) begin
            n_bad++;
            $display("FAIL %s out_valid: actual %0b expected %0b",
                     exp_vld ? "R7" : "R8", out_valid, exp_vld);
        end
        for (int f = 0; f < NF; f++) begin
            n_chk++;
            if (out_data[f*32 +: 32] !== exp_data[f*32 +: 32]) begin
                n_bad++;
                // R1: lane numbered from the most significant end
                $display("FAIL %s R1 lane %0d: actual %h expected %h",
                         exp_vld ? lane_tag(exp_op, exp_src[f*32 +: 32]) : "R8",
                         NF-1-f, out_data[f*32 +: 32], exp_data[f*32 +: 32]);
            end
        end
    endtask

    task automatic step(input logic v, input logic [1:0] op, input logic [REG_W-1:0] d);
        @(negedge clk);
        check_outputs();
        in_valid = v;
        in_op    = op;
        in_data  = d;
        if (v) begin
            exp_vld  = 1'b1;
            exp_op   = op;
            exp_src  = d;
            exp_data = reg_ref(op, d);
        end else begin
            exp_vld = 1'b0;
        end
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    initial begin : main
        logic [REG_W-1:0] w;
        repeat (3) @(negedge clk);
        // R9: reset state
        n_chk++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            n_bad++;
            $display("FAIL R9 reset: actual %0b/%h expected 0/0", out_valid, out_data);
        end
        if (in_ready !== 1'b1) begin
            n_bad++;
            $display("FAIL R7 in_ready: actual %0b expected 1", in_ready);
        end
        n_chk++;
        rst_n = 1'b1;

        // R3 and R4 ceiling corners, one per lane
        step(1'b1, 2'b01, {32'h0000_0000, 32'h0000_0001, 32'h8000_0000, 32'h8000_0001});
        step(1'b1, 2'b01, {32'h0000_0003, 32'hFFFF_FFFF, 32'h0001_2345, 32'h4000_0001});
        step(1'b1, 2'b01, {32'h0000_0002, 32'h0000_0005, 32'h7FFF_FFFF, 32'h0000_0100});
        // R2 parity patterns
        step(1'b1, 2'b00, {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h8000_0007});
        // R8 idle: output data holds
        step(1'b0, 2'b10, {4{32'hDEAD_BEEF}});
        step(1'b0, 2'b00, '0);
        // R5 mirror
        step(1'b1, 2'b10, {32'h0000_0001, 32'h8000_0000, 32'h1234_5678, 32'hF0F0_0001});
        // R6 copy
        step(1'b1, 2'b11, {32'hCAFE_F00D, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0102_0304});
        // R1: lane isolation, one active lane under each function
        step(1'b1, 2'b10, {32'h0, 32'h0, 32'h0000_0001, 32'h0});
        step(1'b1, 2'b01, {32'h0, 32'h0000_0009, 32'h0, 32'h0});

        for (int i = 0; i < 400; i++) begin
            for (int f = 0; f < NF; f++) begin
                rng = next_rng(rng);
                w[f*32 +: 32] = rng;
            end
            rng = next_rng(rng);
            if (rng[3:0] == 4'd0) w[31:0] = 32'h1 << rng[8:4];
            step(rng[7:5] != 3'd0, rng[11:10], w);
        end
        step(1'b0, 2'b00, '0);
        step(1'b0, 2'b00, '0);
        @(negedge clk);
        check_outputs();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule